// File: doc/BRIEF.md
# Busy-Flag Gated Serial Shift Port

This block is an 8-bit synchronous serial port that software drives through a small register bus. A transfer moves one byte out on `ser_out` and, at the same time, shifts one byte in from `ser_in`. The byte goes out most-significant bit first. In master mode the block makes its own shift clock on `sck_out` from the system clock, which serves as the instruction cycle. The clock period is 2, 4 or 8 system cycles. In slave mode a peer supplies the shift clock on `sck_in`. A two-flop synchroniser brings that clock into the system domain, and the block shifts on its edges.

Software loads the data register, then sets a busy flag to start. Hardware clears the flag after exactly eight shifts and sets a completion flag. If the interrupt enable is on, `irq` is raised from that completion flag. Software can clear the busy flag early to cut a transfer short. The register then holds a partial result and no completion is flagged. Every bus write is accepted in the cycle it is presented; the bus has no back-pressure and no ready signal. A read returns data combinationally from `bus_addr`.

Top module: `bshift_port`

## Requirements
- R1: Address 0 is the data register, readable and writable. In each shift, the bit sampled from `ser_in` enters at bit 0. `ser_out` always shows bit 7, so a byte leaves most-significant bit first.
- R2: Control register at address 1: bit 0 enable, bit 1 master (1) or slave (0), bits 3:2 rate, bit 4 interrupt enable. While enable is 0, the busy flag stays 0 and a write of 1 to it is ignored. In that state `sck_out` and `ser_out` stay low and the data register keeps its value.
- R3: In slave mode the port samples on rising edges of `sck_in` and shifts on falling edges, after a two-flop synchroniser. `sck_out` stays low in slave mode.
- R4: In master mode the `sck_out` period is set by the rate field: 00 gives 2 system cycles, 01 gives 4, and 10 or 11 gives 8.
- R5: Status register at address 2: bit 0 busy, bit 1 done. A write sets busy from bit 0 of the write data, and a write of 1 while idle starts a transfer. Hardware clears busy after exactly eight shifts and sets done.
- R6: Writing busy as 0 during a transfer stops shifting at once. The data register then holds the bits shifted so far, and done is not set.
- R7: `irq` is high while done is 1 and interrupt enable is 1. Any write to address 3 clears done.
- R8: `sck_out` idles low and gives exactly eight pulses per master transfer. `ser_in` is sampled on the rising edge and the register shifts on the falling edge.
- R9: If a busy-clear write lands in the cycle of the eighth shift, the write wins: the shift is dropped and done stays 0. If a done-clear write lands in the cycle of completion, done is set.
- R10: After reset, all registers read 0, and `sck_out` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (instruction cycle) |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| ser_in | input | 1 | Serial data input |
| ser_out | output | 1 | Serial data output, MSB first |
| sck_in | input | 1 | External shift clock (slave mode) |
| sck_out | output | 1 | Generated shift clock (master mode) |
| irq | output | 1 | Completion interrupt request |

## Verification
Two events can land in the same cycle: the eighth falling shift edge, which completes a transfer, and a software status write. At the fastest rate, the eighth falling edge comes exactly sixteen cycles after the start write is captured. The bench counts cycles from that write and places a busy-clear write on that exact edge. It expects a seven-bit partial result with done still 0. It then places a done-clear write on the same edge and expects done and `irq` to be set.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_ACK  = 2'd3;

  typedef struct packed {
    logic       ie;
    logic [1:0] rate;
    logic       master;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/bshift_mclk.sv
module bshift_mclk #(
  parameter int DIV_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       sck,
  output logic       rise_ev,
  output logic       fall_ev
);
  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] cnt_q;
  logic             sck_q;
  logic             hit;

  always_comb begin
    case (rate)
      2'b00:   half = DIV_W'(1);
      2'b01:   half = DIV_W'(2);
      default: half = DIV_W'(4);
    endcase
  end

  assign hit     = run && (cnt_q >= half - DIV_W'(1));
  assign rise_ev = hit && !sck_q;
  assign fall_ev = hit && sck_q;
  assign sck     = sck_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (hit) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sck_q);
endmodule

// File: rtl/bshift_sync.sv
module bshift_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_ev,
  output logic fall_ev
);
  logic [2:0] pipe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[1:0], async_in};
  end

  assign rise_ev = pipe_q[1] && !pipe_q[2];
  assign fall_ev = !pipe_q[1] && pipe_q[2];
endmodule

// File: rtl/bshift_shreg.sv
module bshift_shreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          restart,
  input  logic          samp_ev,
  input  logic          shift_ev,
  input  logic          ser_in,
  output logic [DW-1:0] data_q,
  output logic          last
);
  localparam int CW = $clog2(DW);
  logic [CW-1:0] cnt_q;
  logic          samp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      samp_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (samp_ev) samp_q <= ser_in;
      if (load)          data_q <= load_val;
      else if (shift_ev) data_q <= {data_q[DW-2:0], samp_q};
      if (restart)       cnt_q <= '0;
      else if (shift_ev) cnt_q <= cnt_q + CW'(1);
    end
  end

  assign last = (cnt_q == CW'(DW - 1));
endmodule

// File: rtl/bshift_port.sv
module bshift_port
  import bshift_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ser_in,
  output logic          ser_out,
  input  logic          sck_in,
  output logic          sck_out,
  output logic          irq
);
  ctrl_t         ctrl_q;
  logic          busy_q, done_q;
  logic          wr_data, wr_ctrl, wr_stat, wr_ack;
  logic          abort_now, start, complete, last;
  logic          run_m, slave_on;
  logic          m_sck, m_rise, m_fall, s_rise, s_fall;
  logic          samp_ev, shift_ev;
  logic [DW-1:0] data_q;

  assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_stat = bus_wr && (bus_addr == ADDR_STAT);
  assign wr_ack  = bus_wr && (bus_addr == ADDR_ACK);

  assign abort_now = wr_stat && !bus_wdata[0];
  assign start     = wr_stat && bus_wdata[0] && !busy_q && ctrl_q.en;
  assign run_m     = busy_q && ctrl_q.en && ctrl_q.master;
  assign slave_on  = busy_q && ctrl_q.en && !ctrl_q.master;

  bshift_mclk u_mclk (
    .clk(clk), .rst_n(rst_n), .run(run_m), .rate(ctrl_q.rate),
    .sck(m_sck), .rise_ev(m_rise), .fall_ev(m_fall)
  );

  bshift_sync u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sck_in),
    .rise_ev(s_rise), .fall_ev(s_fall)
  );

  assign samp_ev  = m_rise || (slave_on && s_rise);
  assign shift_ev = (m_fall || (slave_on && s_fall)) && !abort_now;
  assign complete = shift_ev && last;

  bshift_shreg #(.DW(DW)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(wr_data), .load_val(bus_wdata),
    .restart(start), .samp_ev(samp_ev), .shift_ev(shift_ev),
    .ser_in(ser_in), .data_q(data_q), .last(last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[4:0]);
      if (!ctrl_q.en)    busy_q <= 1'b0;
      else if (wr_stat)  busy_q <= bus_wdata[0];
      else if (complete) busy_q <= 1'b0;
      if (complete)    done_q <= 1'b1;
      else if (wr_ack) done_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_DATA: bus_rdata = data_q;
      ADDR_CTRL: bus_rdata[4:0] = ctrl_q;
      ADDR_STAT: bus_rdata[1:0] = {done_q, busy_q};
      default:   bus_rdata = '0;
    endcase
  end

  assign ser_out = ctrl_q.en && data_q[DW-1];
  assign sck_out = ctrl_q.en && ctrl_q.master && m_sck;
  assign irq     = done_q && ctrl_q.ie;

  a_r5_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && !wr_stat) |=> !busy_q);
  a_r2_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en && !wr_data) |=> $stable(data_q));
  a_r6_abort_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_now && !done_q) |=> !done_q);
  a_r9_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> done_q);
  a_r3_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.master |=> !sck_out || ctrl_q.master);
endmodule

// File: tb/bshift_port_bench.sv
`timescale 1ns/1ps
module bshift_port_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0, bus_rdata;
  logic       ser_in, ser_out, sck_in = 1'b0, sck_out, irq;
  logic       mode_m = 1'b1, ser_in_s = 1'b0, mon_on = 1'b0;
  logic [7:0] sl_q = 8'd0, bits = 8'd0;
  int         nrise = 0, cyc = 0, rc0 = 0, rc1 = 0;
  int         n_chk = 0, n_fail = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;

  assign ser_in = mode_m ? sl_q[7] : ser_in_s;

  bshift_port u_bshift_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ser_in(ser_in),
    .ser_out(ser_out), .sck_in(sck_in), .sck_out(sck_out), .irq(irq)
  );

  always @(posedge sck_out) if (mon_on) begin
    bits <= {bits[6:0], ser_out};
    if (nrise == 0) rc0 <= cyc;
    if (nrise == 1) rc1 <= cyc;
    nrise <= nrise + 1;
  end
  always @(negedge sck_out) if (mon_on) sl_q <= {sl_q[6:0], 1'b0};

  function automatic int period_of(input logic [1:0] r);
    return (r == 2'b00) ? 2 : (r == 2'b01) ? 4 : 8;
  endfunction

  function automatic logic [7:0] partial(input logic [7:0] o, input logic [7:0] s, input int k);
    logic [15:0] t;
    t = {o, s};
    return t[15-k -: 8];
  endfunction

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic master_xfer(input logic [7:0] d, input logic [7:0] s,
                             input logic [1:0] r, input logic ie);
    logic [7:0] v;
    mode_m = 1'b1;
    bus_write(2'd1, {3'b0, ie, r, 2'b11});
    bus_write(2'd0, d);
    bus_write(2'd3, 8'h00);
    sl_q = s; nrise = 0; mon_on = 1'b1;
    bus_write(2'd2, 8'h01);
    repeat (8 * period_of(r) + 4) @(negedge clk);
    mon_on = 1'b0;
    bus_read(2'd0, v);
    chk("R1", v, s, "received byte");
    chk("R1", bits, d, "sent byte MSB first");
    chk("R8", nrise, 8, "sck pulse count");
    chk("R8", sck_out, 0, "sck idle level");
    chk("R4", rc1 - rc0, period_of(r), "sck period");
    bus_read(2'd2, v);
    chk("R5", v, 8'h02, "status after auto clear");
    chk("R7", irq, ie, "irq on completion");
    bus_write(2'd3, 8'h00);
    #1 chk("R7", irq, 0, "irq after ack");
  endtask

  task automatic abort_xfer(input logic [7:0] d, input logic [7:0] s, input int j);
    mode_m = 1'b1;
    bus_write(2'd1, 8'h13);
    bus_write(2'd0, d);
    sl_q = s; nrise = 0; mon_on = 1'b1;
    bus_write(2'd2, 8'h01);
    repeat (j - 2) @(negedge clk);
    bus_write(2'd2, 8'h00);
    repeat (4) @(negedge clk);
    mon_on = 1'b0;
  endtask

  task automatic slave_xfer(input logic [7:0] d, input logic [7:0] s);
    logic [7:0] v, got;
    mode_m = 1'b0;
    bus_write(2'd1, 8'h11);
    bus_write(2'd0, d);
    bus_write(2'd3, 8'h00);
    bus_write(2'd2, 8'h01);
    got = '0;
    for (int i = 7; i >= 0; i--) begin
      ser_in_s = s[i];
      repeat (6) @(negedge clk);
      sck_in = 1'b1;
      got = {got[6:0], ser_out};
      chk("R3", sck_out, 0, "sck_out quiet in slave mode");
      repeat (6) @(negedge clk);
      sck_in = 1'b0;
    end
    repeat (6) @(negedge clk);
    bus_read(2'd0, v);
    chk("R3", v, s, "slave received byte");
    chk("R3", got, d, "slave sent byte");
    bus_read(2'd2, v);
    chk("R5", v, 8'h02, "slave status after eight edges");
    chk("R7", irq, 1, "slave irq");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, d, s;
    logic [1:0] r;
    logic       ie;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 3; a++) begin
      bus_read(2'(a), v);
      chk("R10", v, 0, "register reset value");
    end
    chk("R10", sck_out, 0, "sck after reset");
    chk("R10", irq, 0, "irq after reset");

    // R2: disabled port ignores start
    bus_write(2'd1, 8'h02);
    bus_write(2'd0, 8'hA5);
    bus_write(2'd2, 8'h01);
    repeat (20) @(negedge clk);
    bus_read(2'd2, v);
    chk("R2", v, 0, "busy while disabled");
    bus_read(2'd0, v);
    chk("R2", v, 8'hA5, "data while disabled");
    chk("R2", sck_out, 0, "sck while disabled");
    chk("R2", ser_out, 0, "ser_out while disabled");

    // directed rates, including 1x
    master_xfer(8'h81, 8'h7E, 2'b00, 1'b1);
    master_xfer(8'h3C, 8'hC3, 2'b11, 1'b0);
    master_xfer(8'hF0, 8'h0F, 2'b10, 1'b1);

    // R6: early aborts after k shifts
    for (int k = 1; k < 8; k += 3) begin
      d = 8'($urandom); s = 8'($urandom);
      abort_xfer(d, s, 2 * k + 1);
      bus_read(2'd0, v);
      chk("R6", v, partial(d, s, k), "partial byte");
      bus_read(2'd2, v);
      chk("R6", v, 0, "status after abort");
      chk("R6", irq, 0, "irq after abort");
    end

    // R9: abort on the eighth shift edge
    d = 8'h5A; s = 8'hC6;
    abort_xfer(d, s, 16);
    bus_read(2'd0, v);
    chk("R9", v, partial(d, s, 7), "abort wins over eighth shift");
    bus_read(2'd2, v);
    chk("R9", v, 0, "no done when abort wins");

    // R9: ack on the completion edge
    mode_m = 1'b1;
    bus_write(2'd0, 8'h96);
    sl_q = 8'h21; nrise = 0; mon_on = 1'b1;
    bus_write(2'd2, 8'h01);
    repeat (14) @(negedge clk);
    bus_write(2'd3, 8'h00);
    repeat (3) @(negedge clk);
    mon_on = 1'b0;
    bus_read(2'd2, v);
    chk("R9", v, 8'h02, "done set wins over ack");
    chk("R9", irq, 1, "irq when set wins");
    bus_write(2'd3, 8'h00);

    // random master transfers
    for (int n = 0; n < 12; n++) begin
      d = 8'($urandom); s = 8'($urandom);
      r = 2'($urandom); ie = 1'($urandom);
      master_xfer(d, s, r, ie);
    end

    // slave transfers
    slave_xfer(8'hB4, 8'h2D);
    for (int n = 0; n < 3; n++) begin
      d = 8'($urandom); s = 8'($urandom);
      slave_xfer(d, s);
      bus_write(2'd3, 8'h00);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule